// File: doc/BRIEF.md
# General-Purpose Register File with Pointer Views and Data-Space Decode

This block holds the thirty-two 8-bit working registers of a small 8-bit RISC core. An ALU step reads two operands through two combinational read ports and writes one result back through a single write port, so the whole step completes in one clock. The top six registers also act as three 16-bit indirect-address pointers. A dedicated pointer port can load a whole 16-bit pair in one clock, which lets the core post-increment or pre-decrement a pointer.

A data-space port lets load/store logic treat the registers as memory. Addresses 0x00 to 0x1F reach register n at address n. The next 64 addresses, 0x20 to 0x5F, are forwarded to the I/O register window as I/O addresses 0x00 to 0x3F. A peripheral fabric outside this block answers those accesses. Addresses from 0x60 upward are not claimed. Instead the block raises a flag, so that external SRAM logic can respond.

Top module: `gpr_file`

## Requirements
- R1: While the synchronous active-low reset is applied at a clock edge, every register becomes 0x00, so all three pointer outputs read 0x0000 afterwards.
- R2: Read ports A and B are combinational and return the register selected by their 5-bit address. During a same-cycle write they return the old value, because there is no bypass.
- R3: When `wr_en` is high at a clock edge, register `wr_addr` takes `wr_data`.
- R4: The pointer outputs are `ptr_x` = {r27,r26}, `ptr_y` = {r29,r28} and `ptr_z` = {r31,r30}. In each pair the lower-numbered register holds bits 7:0.
- R5: When `ptr_we` is high, `ptr_sel` picks the pair: 0 selects X, 1 selects Y, 2 selects Z, and 3 selects none. Both bytes of the selected pair take `ptr_wdata` at the same edge. With `ptr_sel` = 3, no register changes.
- R6: A data-space access at 0x00 to 0x1F reads or writes register n at address n. `ds_rdata` shows that register combinationally.
- R7: A data-space access at 0x20 to 0x5F drives `io_addr` = address − 0x20 and passes `ds_wdata` to `io_wdata`. It raises `io_we` for a write and `io_re` for a read, and `ds_rdata` returns `io_rdata`. No register changes.
- R8: A data-space read or write at 0x60 or above raises `ds_oor`, changes no register, asserts neither `io_we` nor `io_re`, and returns `ds_rdata` = 0x00.
- R9: When an ALU write and a pointer write or data-space write hit the same register in one cycle, the ALU value is stored. The other byte of the pair still takes the pointer value.
- R10: When a pointer write and a data-space write hit the same register in one cycle, the pointer value is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ra_addr | input | 5 | Read port A register index |
| ra_data | output | 8 | Read port A data |
| rb_addr | input | 5 | Read port B register index |
| rb_data | output | 8 | Read port B data |
| wr_en | input | 1 | ALU write enable |
| wr_addr | input | 5 | ALU write register index |
| wr_data | input | 8 | ALU write data |
| ptr_we | input | 1 | Pointer write enable |
| ptr_sel | input | 2 | Pointer pair: 0 = X, 1 = Y, 2 = Z, 3 = none |
| ptr_wdata | input | 16 | Pointer write value |
| ptr_x | output | 16 | Pointer X = {r27,r26} |
| ptr_y | output | 16 | Pointer Y = {r29,r28} |
| ptr_z | output | 16 | Pointer Z = {r31,r30} |
| ds_addr | input | 16 | Data-space address |
| ds_re | input | 1 | Data-space read strobe |
| ds_we | input | 1 | Data-space write strobe |
| ds_wdata | input | 8 | Data-space write data |
| ds_rdata | output | 8 | Data-space read data |
| ds_oor | output | 1 | Access at or above 0x60, not claimed |
| io_addr | output | 6 | I/O window index |
| io_re | output | 1 | I/O window read strobe |
| io_we | output | 1 | I/O window write strobe |
| io_wdata | output | 8 | I/O window write data |
| io_rdata | input | 8 | I/O window read data from the peripheral fabric |

## Verification
The assertions assume that, outside reset, every strobe and address is driven to a known level. The pointer-load property assumes that no ALU write touches the same pair in that cycle. The out-of-range property assumes that neither the ALU port nor the pointer port writes in the same cycle. The bench keeps within these assumptions by parking every strobe low between operations. It raises two write ports together only in the directed cases that test write-port priority, and those cases never combine with the guarded properties.

// File: rtl/gpr_pkg.sv
// Package: shared sizes and encodings for the register file.
// Assumes: an 8-bit core with 32 registers, three pointer pairs at the top.
package gpr_pkg;
    localparam int DW      = 8;
    localparam int NREG    = 32;
    localparam int RAW     = $clog2(NREG);
    localparam int NPTR    = 3;
    localparam int PTR_LO  = NREG - 2 * NPTR;
    localparam int IO_N    = 64;
    localparam int IOAW    = $clog2(IO_N);

    typedef enum logic [1:0] {
        PSEL_X    = 2'd0,
        PSEL_Y    = 2'd1,
        PSEL_Z    = 2'd2,
        PSEL_NONE = 2'd3
    } ptr_sel_e;

    typedef enum logic [1:0] {
        REGION_REG = 2'd0,
        REGION_IO  = 2'd1,
        REGION_OUT = 2'd2
    } ds_region_e;
endpackage

// File: rtl/gpr_ds_decode.sv
// Module: gpr_ds_decode
// Splits a data-space address into register window, I/O window or
// unclaimed space. Purely combinational.
// Assumes: the register window starts at 0 and the I/O window follows it.
module gpr_ds_decode
    import gpr_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int REG_N  = NREG,
    parameter int WIN_N  = IO_N
) (
    input  logic [ADDR_W-1:0]        addr,
    input  logic                     re,
    input  logic                     we,
    output ds_region_e               region,
    output logic [$clog2(REG_N)-1:0] reg_idx,
    output logic [$clog2(WIN_N)-1:0] io_idx,
    output logic                     oor
);
    localparam logic [ADDR_W-1:0] REG_END = ADDR_W'(REG_N);
    localparam logic [ADDR_W-1:0] IO_END  = ADDR_W'(REG_N + WIN_N);

    logic [ADDR_W-1:0] io_off;

    // Classify the address into one of the three regions.
    always_comb begin
        if (addr < REG_END)
            region = REGION_REG;
        else if (addr < IO_END)
            region = REGION_IO;
        else
            region = REGION_OUT;
    end

    // Offsets within each window.
    assign io_off  = addr - REG_END;
    assign reg_idx = addr[$clog2(REG_N)-1:0];
    assign io_idx  = io_off[$clog2(WIN_N)-1:0];

    // Flag only real accesses that fall above both windows.
    assign oor = (re | we) && (region == REGION_OUT);
endmodule

// File: rtl/gpr_rd_mux.sv
// Module: gpr_rd_mux
// One combinational read port over the flattened register bank.
// Assumes: idx always lies within the bank.
module gpr_rd_mux
    import gpr_pkg::*;
#(
    parameter int N_REG = NREG,
    parameter int W     = DW
) (
    input  logic [N_REG*W-1:0]       bank,
    input  logic [$clog2(N_REG)-1:0] idx,
    output logic [W-1:0]             data
);
    // Select the addressed byte with no bypass from any write port.
    always_comb begin
        data = bank[idx*W +: W];
    end
endmodule

// File: rtl/gpr_bank.sv
// Module: gpr_bank
// Register storage with per-register write arbitration.
// Priority, lowest to highest: data-space write, pointer write, ALU write.
// Assumes: the caller gates ds_we to the register window.
module gpr_bank
    import gpr_pkg::*;
#(
    parameter int N_REG  = NREG,
    parameter int W      = DW,
    parameter int N_PAIR = NPTR
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     alu_we,
    input  logic [$clog2(N_REG)-1:0] alu_addr,
    input  logic [W-1:0]             alu_data,
    input  logic                     ptr_we,
    input  logic [1:0]               ptr_idx,
    input  logic [2*W-1:0]           ptr_data,
    input  logic                     ds_we,
    input  logic [$clog2(N_REG)-1:0] ds_addr,
    input  logic [W-1:0]             ds_data,
    output logic [N_REG*W-1:0]       bank
);
    localparam int PBASE = N_REG - 2 * N_PAIR;

    for (genvar g = 0; g < N_REG; g++) begin : g_reg
        localparam logic [$clog2(N_REG)-1:0] MY_IDX = ($clog2(N_REG))'(g);
        localparam bit IS_PTR = (g >= PBASE);
        localparam int PAIR   = IS_PTR ? (g - PBASE) / 2 : 0;
        localparam bit HI     = IS_PTR ? (((g - PBASE) % 2) == 1) : 1'b0;

        logic [W-1:0] q;
        logic [W-1:0] nxt;
        logic         wr;
        logic         ptr_hit;

        // Pointer-pair hit for registers in the pointer range.
        if (IS_PTR) begin : g_ptr
            assign ptr_hit = ptr_we && (ptr_idx == 2'(PAIR));
        end else begin : g_plain
            assign ptr_hit = 1'b0;
        end

        // Pick the winning write source for this register.
        always_comb begin
            wr  = 1'b0;
            nxt = q;
            if (ds_we && ds_addr == MY_IDX) begin
                wr  = 1'b1;
                nxt = ds_data;
            end
            if (ptr_hit) begin
                wr  = 1'b1;
                nxt = HI ? ptr_data[2*W-1:W] : ptr_data[W-1:0];
            end
            if (alu_we && alu_addr == MY_IDX) begin
                wr  = 1'b1;
                nxt = alu_data;
            end
        end

        // Storage flop with synchronous active-low reset.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= '0;
            else if (wr)
                q <= nxt;
        end

        assign bank[g*W +: W] = q;
    end
endmodule

// File: rtl/gpr_file.sv
// Module: gpr_file (top)
// Register file with two read ports, an ALU write port, a 16-bit pointer
// write port and a data-space port that also fronts the I/O window.
// Assumes: the I/O fabric answers io_rdata combinationally for io_addr.
module gpr_file
    import gpr_pkg::*;
#(
    parameter int DS_AW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [RAW-1:0]   ra_addr,
    output logic [DW-1:0]    ra_data,
    input  logic [RAW-1:0]   rb_addr,
    output logic [DW-1:0]    rb_data,
    input  logic             wr_en,
    input  logic [RAW-1:0]   wr_addr,
    input  logic [DW-1:0]    wr_data,
    input  logic             ptr_we,
    input  logic [1:0]       ptr_sel,
    input  logic [2*DW-1:0]  ptr_wdata,
    output logic [2*DW-1:0]  ptr_x,
    output logic [2*DW-1:0]  ptr_y,
    output logic [2*DW-1:0]  ptr_z,
    input  logic [DS_AW-1:0] ds_addr,
    input  logic             ds_re,
    input  logic             ds_we,
    input  logic [DW-1:0]    ds_wdata,
    output logic [DW-1:0]    ds_rdata,
    output logic             ds_oor,
    output logic [IOAW-1:0]  io_addr,
    output logic             io_re,
    output logic             io_we,
    output logic [DW-1:0]    io_wdata,
    input  logic [DW-1:0]    io_rdata
);
    logic [NREG*DW-1:0]  regs_flat;
    ds_region_e          region;
    logic [RAW-1:0]      ds_reg_idx;
    logic [DW-1:0]       ds_reg_data;
    logic [2*DW-1:0]     ptr_view [NPTR];

    gpr_ds_decode #(.ADDR_W(DS_AW), .REG_N(NREG), .WIN_N(IO_N)) u_dec (
        .addr    (ds_addr),
        .re      (ds_re),
        .we      (ds_we),
        .region  (region),
        .reg_idx (ds_reg_idx),
        .io_idx  (io_addr),
        .oor     (ds_oor)
    );

    gpr_bank #(.N_REG(NREG), .W(DW), .N_PAIR(NPTR)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .alu_we   (wr_en),
        .alu_addr (wr_addr),
        .alu_data (wr_data),
        .ptr_we   (ptr_we && (ptr_sel != PSEL_NONE)),
        .ptr_idx  (ptr_sel),
        .ptr_data (ptr_wdata),
        .ds_we    (ds_we && (region == REGION_REG)),
        .ds_addr  (ds_reg_idx),
        .ds_data  (ds_wdata),
        .bank     (regs_flat)
    );

    gpr_rd_mux #(.N_REG(NREG), .W(DW)) u_rd_a (
        .bank (regs_flat), .idx (ra_addr), .data (ra_data)
    );
    gpr_rd_mux #(.N_REG(NREG), .W(DW)) u_rd_b (
        .bank (regs_flat), .idx (rb_addr), .data (rb_data)
    );
    gpr_rd_mux #(.N_REG(NREG), .W(DW)) u_rd_ds (
        .bank (regs_flat), .idx (ds_reg_idx), .data (ds_reg_data)
    );

    // Pointer views: lower-numbered register of each pair is the low byte.
    for (genvar p = 0; p < NPTR; p++) begin : g_pview
        localparam int LO = PTR_LO + 2 * p;
        assign ptr_view[p] = {regs_flat[(LO+1)*DW +: DW], regs_flat[LO*DW +: DW]};
    end

    assign ptr_x = ptr_view[0];
    assign ptr_y = ptr_view[1];
    assign ptr_z = ptr_view[2];

    // I/O window strobes and write data.
    assign io_re    = ds_re && (region == REGION_IO);
    assign io_we    = ds_we && (region == REGION_IO);
    assign io_wdata = ds_wdata;

    // Data-space read return by region.
    always_comb begin
        unique case (region)
            REGION_REG: ds_rdata = ds_reg_data;
            REGION_IO:  ds_rdata = io_rdata;
            default:    ds_rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpr_file_chk.sv
// Module: gpr_file_chk
// Property checker bound to gpr_file.
// Assumes: strobes and addresses are known while rst_n is high.
module gpr_file_chk
    import gpr_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [RAW-1:0]   wr_addr,
    input logic [DW-1:0]    wr_data,
    input logic             ptr_we,
    input logic [1:0]       ptr_sel,
    input logic [2*DW-1:0]  ptr_wdata,
    input logic [2*DW-1:0]  ptr_x,
    input logic [2*DW-1:0]  ptr_y,
    input logic [2*DW-1:0]  ptr_z,
    input logic [15:0]      ds_addr,
    input logic             ds_re,
    input logic             ds_we,
    input logic             ds_oor,
    input logic [IOAW-1:0]  io_addr,
    input logic             io_re,
    input logic             io_we,
    input logic [NREG*DW-1:0] regs_flat
);
    logic           wv_q;
    logic [RAW-1:0] wa_q;
    logic [DW-1:0]  wd_q;

    // Remember the last ALU write so the following cycle can check it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wv_q <= 1'b0;
            wa_q <= '0;
            wd_q <= '0;
        end else begin
            wv_q <= wr_en;
            wa_q <= wr_addr;
            wd_q <= wr_data;
        end
    end

    // R1: leaving reset, all pointers read zero.
    a_r1_reset_zero: assert property (@(posedge clk)
        $rose(rst_n) |-> (ptr_x == '0 && ptr_y == '0 && ptr_z == '0));

    // R3 and R9: an ALU write always lands, whatever else writes.
    a_r3_alu_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wv_q |-> regs_flat[wa_q*DW +: DW] == wd_q);

    // R5: a Z load with no competing ALU write shows up on ptr_z.
    a_r5_ptr_z_load: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_we && ptr_sel == 2'd2 && !wr_en) |=> ptr_z == $past(ptr_wdata));

    // R7: a write into the I/O window forwards the offset address.
    a_r7_io_forward: assert property (@(posedge clk) disable iff (!rst_n)
        (ds_we && ds_addr >= 16'h20 && ds_addr < 16'h60)
            |-> (io_we && io_addr == 6'(ds_addr - 16'h20)));

    // R8: unclaimed addresses raise the flag and touch no I/O strobe.
    a_r8_oor_flag: assert property (@(posedge clk) disable iff (!rst_n)
        ((ds_re || ds_we) && ds_addr >= 16'h60) |-> (ds_oor && !io_we && !io_re));

    // R8: an unclaimed write leaves every register as it was.
    a_r8_oor_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (ds_we && ds_addr >= 16'h60 && !wr_en && !ptr_we) |=> $stable(regs_flat));
endmodule

bind gpr_file gpr_file_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .ptr_we    (ptr_we),
    .ptr_sel   (ptr_sel),
    .ptr_wdata (ptr_wdata),
    .ptr_x     (ptr_x),
    .ptr_y     (ptr_y),
    .ptr_z     (ptr_z),
    .ds_addr   (ds_addr),
    .ds_re     (ds_re),
    .ds_we     (ds_we),
    .ds_oor    (ds_oor),
    .io_addr   (io_addr),
    .io_re     (io_re),
    .io_we     (io_we),
    .regs_flat (regs_flat)
);

// File: tb/gpr_file_test.sv
module gpr_file_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  ra_addr = '0, rb_addr = '0, wr_addr = '0;
    logic [7:0]  ra_data, rb_data, wr_data = '0;
    logic        wr_en = 1'b0, ptr_we = 1'b0;
    logic [1:0]  ptr_sel = 2'd3;
    logic [15:0] ptr_wdata = '0, ptr_x, ptr_y, ptr_z;
    logic [15:0] ds_addr = '0;
    logic        ds_re = 1'b0, ds_we = 1'b0, ds_oor;
    logic [7:0]  ds_wdata = '0, ds_rdata, io_wdata, io_rdata = '0;
    logic [5:0]  io_addr;
    logic        io_re, io_we;

    int n_cmp = 0;
    int n_bad = 0;

    // Each entry: {register index, value}.
    localparam logic [12:0] VEC [10] = '{
        {5'd0,  8'h11}, {5'd1,  8'h22}, {5'd5,  8'h55}, {5'd10, 8'hA0},
        {5'd15, 8'h0F}, {5'd16, 8'hF0}, {5'd20, 8'h3C}, {5'd26, 8'h81},
        {5'd29, 8'h7E}, {5'd31, 8'hFF}
    };

    always #2 clk = ~clk;

    gpr_file uut (
        .clk(clk), .rst_n(rst_n),
        .ra_addr(ra_addr), .ra_data(ra_data),
        .rb_addr(rb_addr), .rb_data(rb_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ptr_we(ptr_we), .ptr_sel(ptr_sel), .ptr_wdata(ptr_wdata),
        .ptr_x(ptr_x), .ptr_y(ptr_y), .ptr_z(ptr_z),
        .ds_addr(ds_addr), .ds_re(ds_re), .ds_we(ds_we),
        .ds_wdata(ds_wdata), .ds_rdata(ds_rdata), .ds_oor(ds_oor),
        .io_addr(io_addr), .io_re(io_re), .io_we(io_we),
        .io_wdata(io_wdata), .io_rdata(io_rdata)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // Advance one edge, then settle away from it.
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        wr_en = 1'b0; ptr_we = 1'b0; ptr_sel = 2'd3;
        ds_re = 1'b0; ds_we = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        step(); step();
        rst_n = 1'b1;
        #1;
        // R1: reset state
        ra_addr = 5'd0; rb_addr = 5'd31; #1;
        check("R1 r0", {8'h0, ra_data}, 16'h0);
        check("R1 r31", {8'h0, rb_data}, 16'h0);
        check("R1 ptr_x", ptr_x, 16'h0);
        check("R1 ptr_y", ptr_y, 16'h0);
        check("R1 ptr_z", ptr_z, 16'h0);

        // R3 / R2: table walk, written by ALU and read on both ports
        for (int i = 0; i < 10; i++) begin
            wr_en = 1'b1; wr_addr = VEC[i][12:8]; wr_data = VEC[i][7:0];
            step();
            idle();
            ra_addr = VEC[i][12:8]; rb_addr = VEC[i][12:8]; #1;
            check("R3 port A", {8'h0, ra_data}, {8'h0, VEC[i][7:0]});
            check("R2 port B", {8'h0, rb_data}, {8'h0, VEC[i][7:0]});
        end
        check("R4 ptr_y from r29", ptr_y, 16'h7E00);

        // R2: no bypass during a same-cycle write
        ra_addr = 5'd5; wr_en = 1'b1; wr_addr = 5'd5; wr_data = 8'h77; #1;
        check("R2 old value during write", {8'h0, ra_data}, 16'h0055);
        step(); idle(); #1;
        check("R2 new value after edge", {8'h0, ra_data}, 16'h0077);

        // R4: pointer byte order
        wr_en = 1'b1; wr_addr = 5'd26; wr_data = 8'h34; step();
        wr_addr = 5'd27; wr_data = 8'h12; step();
        wr_addr = 5'd30; wr_data = 8'hCD; step();
        wr_addr = 5'd31; wr_data = 8'hAB; step();
        idle(); #1;
        check("R4 ptr_x", ptr_x, 16'h1234);
        check("R4 ptr_z", ptr_z, 16'hABCD);

        // R5: pointer load of Y, then sel 3 does nothing
        ptr_we = 1'b1; ptr_sel = 2'd1; ptr_wdata = 16'hBEEF; step();
        idle(); ra_addr = 5'd28; rb_addr = 5'd29; #1;
        check("R5 ptr_y", ptr_y, 16'hBEEF);
        check("R5 r28 low byte", {8'h0, ra_data}, 16'h00EF);
        check("R5 r29 high byte", {8'h0, rb_data}, 16'h00BE);
        ptr_we = 1'b1; ptr_sel = 2'd3; ptr_wdata = 16'h0000; step();
        idle(); #1;
        check("R5 sel none x", ptr_x, 16'h1234);
        check("R5 sel none y", ptr_y, 16'hBEEF);
        check("R5 sel none z", ptr_z, 16'hABCD);

        // R6: data-space register window
        ds_we = 1'b1; ds_addr = 16'h000A; ds_wdata = 8'h5A; #1;
        check("R6 no flag", {15'h0, ds_oor}, 16'h0);
        check("R6 no io_we", {15'h0, io_we}, 16'h0);
        step(); idle();
        ra_addr = 5'd10; ds_re = 1'b1; ds_addr = 16'h000A; #1;
        check("R6 reg via port A", {8'h0, ra_data}, 16'h005A);
        check("R6 ds_rdata", {8'h0, ds_rdata}, 16'h005A);
        ds_addr = 16'h001F; #1;
        check("R6 ds_rdata r31", {8'h0, ds_rdata}, 16'h00AB);
        idle();

        // R7: I/O window
        ds_we = 1'b1; ds_addr = 16'h0025; ds_wdata = 8'h99; #1;
        check("R7 io_we", {15'h0, io_we}, 16'h1);
        check("R7 io_addr", {10'h0, io_addr}, 16'h0005);
        check("R7 io_wdata", {8'h0, io_wdata}, 16'h0099);
        step(); idle();
        ra_addr = 5'd5; #1;
        check("R7 r5 untouched", {8'h0, ra_data}, 16'h0077);
        ds_re = 1'b1; ds_addr = 16'h005F; io_rdata = 8'hC3; #1;
        check("R7 io_re", {15'h0, io_re}, 16'h1);
        check("R7 io_addr top", {10'h0, io_addr}, 16'h003F);
        check("R7 ds_rdata from io", {8'h0, ds_rdata}, 16'h00C3);
        idle();

        // R8: unclaimed space
        ds_we = 1'b1; ds_addr = 16'h0060; ds_wdata = 8'hEE; #1;
        check("R8 flag at 0x60", {15'h0, ds_oor}, 16'h1);
        check("R8 no io_we", {15'h0, io_we}, 16'h0);
        step();
        ds_addr = 16'h0100; step();
        idle(); ra_addr = 5'd0; #1;
        check("R8 r0 untouched", {8'h0, ra_data}, 16'h0011);
        ds_re = 1'b1; ds_addr = 16'h0060; #1;
        check("R8 read zero", {8'h0, ds_rdata}, 16'h0);
        check("R8 no io_re", {15'h0, io_re}, 16'h0);
        idle(); #1;
        check("R8 flag idle", {15'h0, ds_oor}, 16'h0);

        // R9: ALU beats pointer and data-space writes
        wr_en = 1'b1; wr_addr = 5'd26; wr_data = 8'hAA;
        ptr_we = 1'b1; ptr_sel = 2'd0; ptr_wdata = 16'h5555; step();
        idle(); #1;
        check("R9 ALU over pointer", ptr_x, 16'h55AA);
        wr_en = 1'b1; wr_addr = 5'd10; wr_data = 8'h11;
        ds_we = 1'b1; ds_addr = 16'h000A; ds_wdata = 8'h22; step();
        idle(); ra_addr = 5'd10; #1;
        check("R9 ALU over data space", {8'h0, ra_data}, 16'h0011);

        // R10: pointer beats data-space write
        ptr_we = 1'b1; ptr_sel = 2'd2; ptr_wdata = 16'h1357;
        ds_we = 1'b1; ds_addr = 16'h001E; ds_wdata = 8'h99; step();
        idle(); #1;
        check("R10 pointer over data space", ptr_z, 16'h1357);

        // R1: reset again clears everything
        rst_n = 1'b0; step(); rst_n = 1'b1; #1;
        check("R1 reset clears x", ptr_x, 16'h0);
        check("R1 reset clears z", ptr_z, 16'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule